// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block sends asynchronous serial characters on a single output line. A host writes characters into a one-entry holding buffer. The block moves each character into a transmit shift register as soon as that register is free, so the host can queue the next character while the current one is still on the line. Frames carry either 8 or 9 data bits. In 9-bit mode the extra bit comes from a control-register field. That field is captured at the moment of the buffer-to-shifter transfer, so later control writes cannot alter a frame that is already in flight.

A programmable divider of the system clock sets the bit rate. The divider runs freely while transmission is enabled. Writing the control register does not restart it, so the timing of a frame in flight is never disturbed. The host sees two flags. One reports that the holding buffer is empty and can take a character. The other reports that the shifter has nothing left to send. Register writes go through a small address/data port. Each write takes one cycle and there is no handshake.

Top module: `dbl_uart_tx`

## Requirements
- R1: After reset the line is high, and both the buffer-empty flag and the shifter-empty flag are 1.
- R2: A frame consists of a low start bit, then the data bits least significant first, then one high stop bit. In 8-bit mode a frame is 10 bits long.
- R3: When control bit 1 is set, each frame carries 9 data bits. The ninth bit, sent after data bit 7, takes the value of control bit 2.
- R4: The ninth bit is captured when the character moves from the buffer into the shifter. A control write after that point does not change the frame.
- R5: Every bit lasts exactly divisor+1 clock cycles, and the line changes only on a baud tick. Control writes do not restart the divider. While control bit 0 (enable) is 0, no tick occurs, no frame makes progress and the line stays high.
- R6: A data write clears the buffer-empty flag in the following cycle. If the shifter is idle, the flag sets again on the next clock edge, because the character has moved into the shifter.
- R7: When a character is already waiting, the handoff happens on the edge where the current frame's stop bit begins, and the buffer-empty flag rises on that same edge. The next start bit then begins exactly one bit period later, so back-to-back frames are spaced (data bits + 2) × (divisor + 1) cycles apart.
- R8: The shifter-empty flag is 0 from the transfer until the end of the last queued frame's stop bit, and it rises on the edge that ends that stop bit.
- R9: Each accepted data write produces exactly one frame, whatever the timing of the write relative to the stop bit.
- R10: The write port decodes addresses as follows: 0 is data (wrData[7:0]), 1 is control (bit 0 enable, bit 1 nine-bit mode, bit 2 ninth-bit value), and 2 is the divisor (wrData[15:0]). A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register select: 0 data, 1 control, 2 divisor |
| wrData | input | 16 | Write data |
| txLine | output | 1 | Serial output, idles high |
| bufEmpty | output | 1 | Holding buffer can accept a character |
| shiftEmpty | output | 1 | No frame is being shifted out |

## Verification
The hardest case to reach is a data write that lands in the same cycle as the baud tick closing a stop bit, with the buffer being loaded while the shifter hands over. It is hard to reach because the divider phase is not visible at the ports. The bench therefore sends one character and then delays a second write by every cycle offset from zero to beyond a whole frame. This sweeps the write across the start bit, the data bits, every cycle of the stop bit and the idle time after it. For each offset the bench checks that exactly two frames arrive with the right contents. Long back-to-back streams in both frame sizes also check the handoff edge and the exact spacing between frames.

// File: rtl/dbl_uart_tx_pkg.sv
package dbl_uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SHIFT,
    ST_STOP,
    ST_STOP_ARMED
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic driveData;
  } txStrobe_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  localparam int CTRL_EN_POS    = 0;
  localparam int CTRL_NINE_POS  = 1;
  localparam int CTRL_NINTH_POS = 2;

endpackage

// File: rtl/dbl_uart_tx_baud.sv
module dbl_uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // counter only clears when disabled or on its own tick
  assign tick = enable && (cnt >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!enable || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dbl_uart_tx_datapath.sv
module dbl_uart_tx_datapath
  import dbl_uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 16,
  parameter int BUS_W     = 16,
  parameter int DIV_RESET = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  input  txStrobe_t        strobe,
  output logic             bufFull,
  output logic             txEnable,
  output logic             nineMode,
  output logic [DIV_W-1:0] divisor,
  output logic             txLine
);

  localparam int SH_W = DATA_W + 2;

  logic [DATA_W-1:0] bufData;
  logic              ninthVal;
  logic [SH_W-1:0]   shreg;
  logic              dataWr;
  logic              ctrlWr;
  logic              divWr;

  assign dataWr = wrEn && (wrAddr == ADDR_DATA);
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign divWr  = wrEn && (wrAddr == ADDR_DIV);

  // control and divisor registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnable <= 1'b0;
      nineMode <= 1'b0;
      ninthVal <= 1'b0;
      divisor  <= DIV_W'(DIV_RESET);
    end else begin
      if (ctrlWr) begin
        txEnable <= wrData[CTRL_EN_POS];
        nineMode <= wrData[CTRL_NINE_POS];
        ninthVal <= wrData[CTRL_NINTH_POS];
      end
      if (divWr) begin
        divisor <= wrData[DIV_W-1:0];
      end
    end
  end

  // holding buffer: a write on a load edge refills it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      bufFull <= 1'b0;
    end else if (dataWr) begin
      bufData <= wrData[DATA_W-1:0];
      bufFull <= 1'b1;
    end else if (strobe.load) begin
      bufFull <= 1'b0;
    end
  end

  // shift register: bit 0 is the start bit, ninth bit captured here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg <= '1;
    end else if (strobe.load) begin
      shreg <= {(nineMode ? ninthVal : 1'b1), bufData, 1'b0};
    end else if (strobe.shift) begin
      shreg <= {1'b1, shreg[SH_W-1:1]};
    end
  end

  assign txLine = strobe.driveData ? shreg[0] : 1'b1;

endmodule

// File: rtl/dbl_uart_tx_ctrl.sv
module dbl_uart_tx_ctrl
  import dbl_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      bufFull,
  input  logic      nineMode,
  output txStrobe_t strobe,
  output logic      shiftEmpty
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] SHIFTS_SHORT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] SHIFTS_LONG  = CNT_W'(DATA_W + 1);

  txState_e         state, stateNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             frameNine;
  logic             loadNow;
  logic             shiftNow;
  logic             lastBit;

  assign lastBit = (bitCnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = bitCnt;
    loadNow   = 1'b0;
    shiftNow  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (bufFull) begin
          loadNow   = 1'b1;
          stateNext = ST_ARMED;
        end
      end
      ST_ARMED, ST_STOP_ARMED: begin
        if (tick) begin
          stateNext = ST_SHIFT;
          cntNext   = frameNine ? SHIFTS_LONG : SHIFTS_SHORT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (lastBit) begin
            // stop bit begins: hand over a waiting character now
            loadNow   = bufFull;
            stateNext = bufFull ? ST_STOP_ARMED : ST_STOP;
          end else begin
            shiftNow = 1'b1;
            cntNext  = bitCnt - 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (bufFull) begin
          loadNow   = 1'b1;
          stateNext = tick ? ST_ARMED : ST_STOP_ARMED;
        end else if (tick) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      frameNine <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
      if (loadNow) begin
        frameNine <= nineMode;
      end
    end
  end

  assign strobe.load      = loadNow;
  assign strobe.shift     = shiftNow;
  assign strobe.driveData = (state == ST_SHIFT);
  assign shiftEmpty       = (state == ST_IDLE);

endmodule

// File: rtl/dbl_uart_tx.sv
module dbl_uart_tx
  import dbl_uart_tx_pkg::*;
#(
  parameter  int DATA_W    = 8,
  parameter  int DIV_W     = 16,
  parameter  int DIV_RESET = 15,
  localparam int BUS_W     = (DIV_W > DATA_W) ? DIV_W : DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  output logic             txLine,
  output logic             bufEmpty,
  output logic             shiftEmpty
);

  txStrobe_t        strobe;
  logic             bufFull;
  logic             txEnable;
  logic             nineMode;
  logic [DIV_W-1:0] divisor;
  logic             baudTick;

  dbl_uart_tx_baud #(
    .DIV_W(DIV_W)
  ) baud_i (
    .clk    (clk),
    .rstN   (rstN),
    .enable (txEnable),
    .divisor(divisor),
    .tick   (baudTick)
  );

  dbl_uart_tx_datapath #(
    .DATA_W   (DATA_W),
    .DIV_W    (DIV_W),
    .BUS_W    (BUS_W),
    .DIV_RESET(DIV_RESET)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .bufFull (bufFull),
    .txEnable(txEnable),
    .nineMode(nineMode),
    .divisor (divisor),
    .txLine  (txLine)
  );

  dbl_uart_tx_ctrl #(
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (baudTick),
    .bufFull   (bufFull),
    .nineMode  (nineMode),
    .strobe    (strobe),
    .shiftEmpty(shiftEmpty)
  );

  assign bufEmpty = !bufFull;

endmodule

// File: rtl/dbl_uart_tx_chk.sv
module dbl_uart_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       txLine,
  input logic       bufEmpty,
  input logic       shiftEmpty,
  input logic       baudTick,
  input logic       txEnable
);

  // R1: an empty shifter never drives a low level
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txLine);

  // R5: the line only moves right after a baud tick
  a_r5_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(baudTick));

  // R5: no ticks while disabled
  a_r5_no_tick_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !baudTick);

  // R6: a data write leaves the buffer occupied in the next cycle
  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> !bufEmpty);

  // R10: without a data write an empty buffer stays empty
  a_r10_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && !(wrEn && wrAddr == 2'd0)) |=> bufEmpty);

  // R8: a handoff always leaves the shifter occupied
  a_r8_handoff_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> !shiftEmpty);

endmodule

bind dbl_uart_tx dbl_uart_tx_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .txLine    (txLine),
  .bufEmpty  (bufEmpty),
  .shiftEmpty(shiftEmpty),
  .baudTick  (baudTick),
  .txEnable  (txEnable)
);

// File: tb/dbl_uart_tx_tb_top.sv
module dbl_uart_tx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        txLine;
  logic        bufEmpty;
  logic        shiftEmpty;

  always #5 clk = ~clk;

  dbl_uart_tx dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .txLine    (txLine),
    .bufEmpty  (bufEmpty),
    .shiftEmpty(shiftEmpty)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int nb = 8;          // data bits per frame
  int bitP = 16;       // clocks per bit
  int expVal [0:1023];
  int rxVal [0:1023];
  int rxStart [0:1023];
  int expCount = 0;
  int rxCount = 0;
  int checkedUpTo = 0;
  bit streamMode = 0;
  int streamBase = 0;
  int streamTotal = 0;

  // decoder state
  logic [11:0] bitv;
  bit glitch;
  int dStart, fb, fp, val;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", rxCount, expCount);
    finishRun();
  end

  // line decoder, samples on falling clock edges
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txLine === 1'b0) begin
        dStart = cyc;
        fp = bitP;
        fb = nb + 2;
        glitch = 0;
        bitv = '1;
        chk(shiftEmpty === 1'b0, "R8 shifter busy during frame", shiftEmpty, 0);
        for (int i = 0; i < fb * fp; i++) begin
          if (i > 0) @(negedge clk);
          if (i % fp == 0) bitv[i / fp] = txLine;
          else if (txLine !== bitv[i / fp]) glitch = 1;
          if (streamMode && i == (fb - 1) * fp)
            chk(bufEmpty === 1'b1, "R7 handoff at stop start", bufEmpty, 1);
          if (streamMode && i == (fb - 1) * fp - 1 && (rxCount - streamBase) < streamTotal - 1)
            chk(bufEmpty === 1'b0, "R7 buffer held until stop", bufEmpty, 0);
        end
        val = 0;
        for (int k = 0; k < fb - 2; k++) val = val | (int'(bitv[k + 1]) << k);
        chk(bitv[0] === 1'b0 && bitv[fb - 1] === 1'b1, "R2 start low and stop high",
            {bitv[0], bitv[fb - 1]}, 1);
        chk(!glitch, "R5 bit length divisor+1", glitch, 0);
        if (streamMode && rxCount > streamBase)
          chk(dStart - rxStart[rxCount - 1] == fb * fp, "R7 back-to-back spacing",
              dStart - rxStart[rxCount - 1], fb * fp);
        rxVal[rxCount] = val;
        rxStart[rxCount] = dStart;
        rxCount++;
      end
    end
  end

  // called on a falling edge, returns on the next falling edge
  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1;
    wrAddr = a;
    wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendChar(input int v);
    expVal[expCount] = v;
    expCount++;
    wr(2'd0, v & 8'hFF);
  endtask

  task automatic waitIdle();
    while (rxCount != expCount) @(posedge clk);
    @(negedge clk);
    chk(shiftEmpty === 1'b1 && bufEmpty === 1'b1, "R8 shifter empty at stop end",
        {bufEmpty, shiftEmpty}, 3);
  endtask

  task automatic checkFrames(input string tag);
    chk(rxCount == expCount, {"R9 frame count ", tag}, rxCount, expCount);
    for (int i = checkedUpTo; i < expCount && i < rxCount; i++)
      chk(rxVal[i] == expVal[i], {"R2 R3 data ", tag}, rxVal[i], expVal[i]);
    checkedUpTo = expCount;
  endtask

  function automatic int ctrlWord(input bit en, input bit nine, input bit ninth);
    return {ninth, nine, en};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLine === 1'b1, "R1 line idle high", txLine, 1);
    chk(bufEmpty === 1'b1 && shiftEmpty === 1'b1, "R1 flags after reset",
        {bufEmpty, shiftEmpty}, 3);

    // R10 address 3 ignored
    wr(2'd3, 16'h00FF);
    @(negedge clk);
    chk(bufEmpty === 1'b1 && shiftEmpty === 1'b1 && txLine === 1'b1,
        "R10 address 3 no effect", {bufEmpty, shiftEmpty, txLine}, 7);

    // R5 disabled: character waits, line stays high
    wr(2'd2, 1);
    bitP = 2;
    nb = 8;
    wr(2'd1, ctrlWord(0, 0, 0));
    sendChar(8'h5A);
    chk(bufEmpty === 1'b0, "R6 flag clears after write", bufEmpty, 0);
    @(negedge clk);
    chk(bufEmpty === 1'b1 && shiftEmpty === 1'b0, "R6 transfer into idle shifter",
        {bufEmpty, shiftEmpty}, 2);
    repeat (40) @(negedge clk);
    chk(rxCount == 0 && txLine === 1'b1, "R5 no frame while disabled", rxCount, 0);
    wr(2'd1, ctrlWord(1, 0, 0));
    waitIdle();
    checkFrames("enable");

    // R2 R7 R9 exhaustive 8-bit back-to-back stream
    streamBase = rxCount;
    streamTotal = 256;
    streamMode = 1;
    for (int i = 0; i < 256; i++) begin
      while (bufEmpty !== 1'b1) @(negedge clk);
      sendChar(i);
    end
    waitIdle();
    streamMode = 0;
    checkFrames("8-bit stream");

    // R3 R4 9-bit stream with the ninth bit rewritten mid-frame
    wr(2'd2, 3);
    bitP = 4;
    nb = 9;
    streamBase = rxCount;
    streamTotal = 64;
    streamMode = 1;
    for (int i = 0; i < 64; i++) begin
      while (bufEmpty !== 1'b1) @(negedge clk);
      wr(2'd1, ctrlWord(1, 1, i[0]));
      sendChar((int'(i[0]) << 8) | ((i * 37 + 5) & 8'hFF));
    end
    waitIdle();
    streamMode = 0;
    checkFrames("9-bit stream");

    // R4 explicit: control write during the frame does not alter it
    wr(2'd1, ctrlWord(1, 1, 1));
    sendChar(9'h1C3);
    repeat (12) @(negedge clk);
    wr(2'd1, ctrlWord(1, 1, 0));
    waitIdle();
    sendChar(9'h03C);
    waitIdle();
    checkFrames("R4 ninth capture");

    // R5 divisor sweep in 8-bit mode
    nb = 8;
    wr(2'd1, ctrlWord(1, 0, 0));
    for (int dv = 0; dv < 7; dv += 3) begin
      wr(2'd2, dv);
      bitP = dv + 1;
      sendChar(8'hA5 ^ dv);
      waitIdle();
      sendChar(8'h0F + dv);
      waitIdle();
    end
    checkFrames("divisor sweep");

    // R9 second write swept across the whole first frame and its stop bit
    wr(2'd2, 1);
    bitP = 2;
    for (int d = 0; d < 26; d++) begin
      sendChar(8'h80 | d);
      @(negedge clk);
      repeat (d) @(negedge clk);
      sendChar(8'h40 + d);
      waitIdle();
      checkFrames("stop coincidence sweep");
    end

    finishRun();
  end

endmodule